// File: doc/BRIEF.md
# Interrupt Event Masking and Status Queue

This block sits beside a serial-bus remote terminal and turns the terminal's single-cycle event pulses into host interrupts. Each event is first gated by an enable bit, split across two mask registers. An enabled event then sets a sticky status bit. The host interrupt request is asserted while any status bit that is still enabled is set.

Each enabled event is also recorded in a circular queue in external word RAM. A record is two words: a vector word with one bit per event, then a parameter word. The parameter word is the descriptor pointer supplied with the event. Events that fire in the same cycle share one record. The queue write pointer can be read back, and a wrap of the queue raises its own interrupt.

The host uses a simple register port: a write strobe, a two-bit address and combinational read data. Bus decoding and event generation are done elsewhere.

Top module: `irq_event_queue`

## Requirements
- R1: Event and status bit positions are: 0 end of message, 1 message error, 2 selected subaddress, 3 selected mode code, 4 circular buffer full rollover, 5 circular buffer half rollover, 6 descriptor stack full rollover, 7 descriptor stack half rollover, 8 transmitter timeout, 9 illegal command, 10 queue wrap, 11 monitor stack half rollover, 12 monitor data half rollover.
- R2: Register address 0 bits 7:0 enable events 0 to 7, and address 1 bits 4:0 enable events 8 to 12. Both reset to zero. A disabled event sets no status bit and writes no queue record.
- R3: The status register is at address 2. An enabled event sets its bit at the clock edge that samples the pulse. The bit stays set until the host writes a 1 to it. Writing 0 has no effect. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: `irq` is high exactly when some status bit is set and its enable bit is also set. Clearing an enable drops `irq` without clearing status.
- R5: After the edge that samples an enabled event, `q_we` is high for two cycles. The first cycle writes the vector word at the queue pointer. The second writes the descriptor pointer at the queue pointer plus 1.
- R6: Enabled events that fire in the same cycle produce a single record whose vector word has every one of their bits set.
- R7: The queue pointer is readable at address 3 and resets to 0. It advances by 2 when a record completes and wraps from 62 to 0 in a 64-location queue.
- R8: Status bit 10 is set only when a record is written at the last pair of locations and enable bit 10 is set. It is never set by `evt_in[10]`, and bit 10 never appears in a vector word.
- R9: Enabled events that arrive while a record is being written are merged into one pending record. That record holds the OR of their bits and the latest descriptor pointer, and it is written immediately after the current record.
- R10: In reset, all masks, status bits and the queue pointer are zero, and both `irq` and `q_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 13 | Event pulses, one bit per source (R1) |
| desc_ptr | input | 16 | Descriptor pointer for the events of this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Host interrupt request |
| q_we | output | 1 | Queue RAM write enable |
| q_addr | output | 6 | Queue RAM word address |
| q_wdata | output | 16 | Queue RAM write data |

## Verification
The bench uses the defaults: 16-bit words and a 64-location queue. With those values a wrap takes only 32 records, so the bench drives the pointer through the wrap from 62 to 0. It checks the wrap status bit and the record written at the last pair of locations. Because records are two cycles long, the bench can also place events in both cycles of a record and observe the merged pending record that follows.

// File: rtl/irqq_pkg.sv
// Shared constants for the interrupt event queue.
// Assumes 13 event sources with the bit map given in the brief.
package irqq_pkg;
    localparam int EVT_W     = 13;
    localparam int MASK_LO_W = 8;
    localparam int MASK_HI_W = EVT_W - MASK_LO_W;
    localparam int EV_QWRAP  = 10;

    // Sources that may be written to the queue (the wrap source may not).
    localparam logic [EVT_W-1:0] LOG_SEL = ~(EVT_W'(1) << EV_QWRAP);

    localparam logic [1:0] RA_MASK_LO = 2'd0;
    localparam logic [1:0] RA_MASK_HI = 2'd1;
    localparam logic [1:0] RA_STATUS  = 2'd2;
    localparam logic [1:0] RA_QPTR    = 2'd3;

    typedef enum logic [1:0] {PH_IDLE, PH_VEC, PH_PAR} wr_phase_e;
endpackage

// File: rtl/irqq_status.sv
// Enable registers, sticky status bits and the interrupt request.
// Assumes event pulses are already merged with the internal wrap pulse.
module irqq_status
    import irqq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             mask_we_lo,
    input  logic             mask_we_hi,
    input  logic             clr_we,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] mask,
    output logic [EVT_W-1:0] status,
    output logic             irq
);
    logic [MASK_LO_W-1:0] mask_lo;
    logic [MASK_HI_W-1:0] mask_hi;
    logic [EVT_W-1:0]     status_nxt;

    assign mask = {mask_hi, mask_lo};

    // Enable register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lo <= '0;
            mask_hi <= '0;
        end else begin
            if (mask_we_lo) mask_lo <= wdata[MASK_LO_W-1:0];
            if (mask_we_hi) mask_hi <= wdata[MASK_HI_W-1:0];
        end
    end

    // Next status: enabled events set bits, write-one clears the rest.
    always_comb begin
        for (int i = 0; i < EVT_W; i++) begin
            if (evt[i] && mask[i])
                status_nxt[i] = 1'b1;
            else if (clr_we && wdata[i])
                status_nxt[i] = 1'b0;
            else
                status_nxt[i] = status[i];
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    // Request line: any set bit whose enable is still set.
    assign irq = |(status & mask);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status)));

    assert_masked_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(mask)) == '0));
endmodule

// File: rtl/irqq_writer.sv
// Writes two-word records (vector, descriptor pointer) into the circular
// queue and keeps one pending record for events that arrive while busy.
// Assumes DEPTH is an even power of two.
module irqq_writer
    import irqq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int QA_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  new_vec,
    input  logic [DATA_W-1:0] new_par,
    output logic              q_we,
    output logic [QA_W-1:0]   q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [QA_W-1:0]   qptr,
    output logic              wrap
);
    localparam logic [QA_W-1:0] LAST_PAIR = QA_W'(DEPTH - 2);

    wr_phase_e         phase;
    logic [EVT_W-1:0]  cur_vec, pend_vec;
    logic [DATA_W-1:0] cur_par, pend_par;
    logic              pend_v;
    logic              new_any;

    assign new_any = |new_vec;

    // Record sequencing, pending merge and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cur_vec  <= '0;
            cur_par  <= '0;
            pend_vec <= '0;
            pend_par <= '0;
            pend_v   <= 1'b0;
            qptr     <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (new_any) begin
                        cur_vec <= new_vec;
                        cur_par <= new_par;
                        phase   <= PH_VEC;
                    end
                end
                PH_VEC: begin
                    phase <= PH_PAR;
                    if (new_any) begin
                        pend_vec <= pend_vec | new_vec;
                        pend_par <= new_par;
                        pend_v   <= 1'b1;
                    end
                end
                PH_PAR: begin
                    qptr <= qptr + QA_W'(2);
                    if (pend_v || new_any) begin
                        cur_vec  <= pend_vec | new_vec;
                        cur_par  <= new_any ? new_par : pend_par;
                        pend_vec <= '0;
                        pend_v   <= 1'b0;
                        phase    <= PH_VEC;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // RAM port: vector word at even address, pointer word at odd address.
    always_comb begin
        q_we    = (phase != PH_IDLE);
        q_addr  = (phase == PH_PAR) ? (qptr | QA_W'(1)) : qptr;
        q_wdata = (phase == PH_PAR) ? cur_par : DATA_W'(cur_vec);
    end

    // Wrap pulse when the last pair of locations completes.
    assign wrap = (phase == PH_PAR) && (qptr == LAST_PAIR);

    assert_word_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && !q_addr[0]) |=> (q_we && q_addr == $past(q_addr) + QA_W'(1)));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAR) |=> (qptr == $past(qptr) + QA_W'(2)));

    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (qptr == '0));
endmodule

// File: rtl/irq_event_queue.sv
// Top: register decode and read mux, with the status and writer units.
// Assumes a single-cycle register port with combinational read data.
module irq_event_queue
    import irqq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int QUEUE_DEPTH = 64,
    parameter int QA_W        = $clog2(QUEUE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic [DATA_W-1:0] desc_ptr,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              q_we,
    output logic [QA_W-1:0]   q_addr,
    output logic [DATA_W-1:0] q_wdata
);
    logic [EVT_W-1:0] mask, status, evt_all, log_vec;
    logic [QA_W-1:0]  qptr;
    logic             wrap;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:EVT_W];

    // External sources (without the wrap position) plus the internal wrap pulse.
    assign evt_all = (evt_in & LOG_SEL) | (EVT_W'(wrap) << EV_QWRAP);
    assign log_vec = evt_in & LOG_SEL & mask;

    irqq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_all),
        .mask_we_lo (reg_we && reg_addr == RA_MASK_LO),
        .mask_we_hi (reg_we && reg_addr == RA_MASK_HI),
        .clr_we     (reg_we && reg_addr == RA_STATUS),
        .wdata      (reg_wdata[EVT_W-1:0]),
        .mask       (mask),
        .status     (status),
        .irq        (irq)
    );

    irqq_writer #(.DATA_W(DATA_W), .DEPTH(QUEUE_DEPTH), .QA_W(QA_W)) u_writer (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_vec (log_vec),
        .new_par (desc_ptr),
        .q_we    (q_we),
        .q_addr  (q_addr),
        .q_wdata (q_wdata),
        .qptr    (qptr),
        .wrap    (wrap)
    );

    // Register read mux.
    always_comb begin
        case (reg_addr)
            RA_MASK_LO: reg_rdata = DATA_W'(mask[MASK_LO_W-1:0]);
            RA_MASK_HI: reg_rdata = DATA_W'(mask[EVT_W-1:MASK_LO_W]);
            RA_STATUS:  reg_rdata = DATA_W'(status);
            default:    reg_rdata = DATA_W'(qptr);
        endcase
    end

    assert_no_wrap_in_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && !q_addr[0]) |-> !q_wdata[EV_QWRAP]);
endmodule

// File: tb/irq_event_queue_tb.sv
// Directed bench for irq_event_queue: one task per scenario.
module irq_event_queue_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] evt_in;
    logic [15:0] desc_ptr;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        q_we;
    logic [5:0]  q_addr;
    logic [15:0] q_wdata;

    int checks = 0;
    int errors = 0;
    int exp_qptr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_event_queue u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .desc_ptr(desc_ptr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .q_we(q_we), .q_addr(q_addr),
        .q_wdata(q_wdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Drive events for one edge; returns at the negedge where the vector word shows.
    task automatic pulse(input logic [12:0] e, input logic [15:0] p);
        evt_in = e; desc_ptr = p;
        @(posedge clk); @(negedge clk);
        evt_in = '0;
    endtask

    // Check a full record starting at the current negedge, then advance the model.
    task automatic expect_record(input string tag, input int vec, input int par);
        check({tag, " vec we"}, int'(q_we), 1);
        check({tag, " vec addr"}, int'(q_addr), exp_qptr);
        check({tag, " vec data"}, int'(q_wdata), vec);
        @(negedge clk);
        check({tag, " par addr"}, int'(q_addr), exp_qptr + 1);
        check({tag, " par data"}, int'(q_wdata), par);
        @(negedge clk);
        exp_qptr = (exp_qptr + 2) % 64;
    endtask

    task automatic t_reset();
        int v;
        check("R10 irq", int'(irq), 0);
        check("R10 q_we", int'(q_we), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R10 reg", v, 0);
        end
    endtask

    task automatic t_mask_block();
        int v;
        pulse(13'h0001, 16'h1111);
        check("R2 no write", int'(q_we), 0);
        rd(2, v); check("R2 no status", v, 0);
        check("R2 no irq", int'(irq), 0);
        wr(0, 16'h0001);
        pulse(13'h0002, 16'h2222);
        check("R2 other bit no write", int'(q_we), 0);
        rd(2, v); check("R2 other bit no status", v, 0);
    endtask

    task automatic t_single();
        int v;
        wr(0, 16'h00FF);
        wr(1, 16'h001F);
        rd(1, v); check("R2 mask hi readback", v, 16'h001F);
        pulse(13'h0001, 16'h1234);
        rd(2, v); check("R3 status set", v, 16'h0001);
        check("R4 irq high", int'(irq), 1);
        expect_record("R5 single", 16'h0001, 16'h1234);
        check("R5 we low after", int'(q_we), 0);
        rd(3, v); check("R7 qptr", v, exp_qptr);
    endtask

    task automatic t_merge();
        int v;
        pulse(13'h0202, 16'h0ABC);
        rd(2, v); check("R6 status R1 bits", v, 16'h0203);
        expect_record("R6 merged", 16'h0202, 16'h0ABC);
        check("R6 single record", int'(q_we), 0);
    endtask

    task automatic t_clear();
        int v;
        wr(2, 16'h0002);
        rd(2, v); check("R3 clear one", v, 16'h0201);
        wr(2, 16'h0000);
        rd(2, v); check("R3 write zero", v, 16'h0201);
        wr(2, 16'h0201);
        rd(2, v); check("R3 clear all", v, 0);
        check("R4 irq low", int'(irq), 0);
        evt_in = 13'h0008; desc_ptr = 16'h0333;
        reg_we = 1'b1; reg_addr = 2; reg_wdata = 16'h0008;
        @(posedge clk); @(negedge clk);
        evt_in = '0; reg_we = 1'b0;
        rd(2, v); check("R3 set wins", v, 16'h0008);
        expect_record("R3 set wins rec", 16'h0008, 16'h0333);
        wr(0, 16'h00F7);
        rd(2, v); check("R4 status kept", v, 16'h0008);
        check("R4 irq masked off", int'(irq), 0);
        wr(0, 16'h00FF);
        check("R4 irq back", int'(irq), 1);
        wr(2, 16'h0008);
    endtask

    task automatic t_ignore_wrap_input();
        int v;
        pulse(13'h0400, 16'h0444);
        check("R8 input ignored we", int'(q_we), 0);
        rd(2, v); check("R8 input ignored status", v, 0);
    endtask

    task automatic t_pending();
        int v;
        int base;
        base = exp_qptr;
        pulse(13'h0001, 16'hA001);
        check("R9 A vec", int'(q_wdata), 16'h0001);
        check("R9 A addr", int'(q_addr), base);
        evt_in = 13'h0004; desc_ptr = 16'hB002;
        @(posedge clk); @(negedge clk);
        check("R9 A par", int'(q_wdata), 16'hA001);
        evt_in = 13'h0100; desc_ptr = 16'hC003;
        @(posedge clk); @(negedge clk);
        evt_in = '0;
        exp_qptr = (exp_qptr + 2) % 64;
        expect_record("R9 pending", 16'h0104, 16'hC003);
        check("R9 idle", int'(q_we), 0);
        rd(3, v); check("R9 qptr", v, exp_qptr);
        wr(2, 16'h1FFF);
    endtask

    task automatic t_wrap();
        int v;
        int n;
        n = (64 - exp_qptr) / 2;
        for (int i = 0; i < n; i++) begin
            pulse(13'h0001, 16'(i));
            if (i == n - 1) begin
                rd(2, v); check("R8 no wrap yet", v & 16'h0400, 0);
            end
            expect_record("R7 fill", 16'h0001, i);
        end
        rd(3, v); check("R7 wrapped qptr", v, 0);
        rd(2, v); check("R8 wrap status", v & 16'h0400, 16'h0400);
        check("R8 irq", int'(irq), 1);
    endtask

    initial begin
        rst_n = 1'b0; evt_in = '0; desc_ptr = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_block();
        t_single();
        t_merge();
        t_clear();
        t_ignore_wrap_input();
        t_pending();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule